// File: doc/BRIEF.md
# ECC-protected word store with byte writes

The block holds data as 32-bit words. Each word is kept next to 6 check bits of a single-error-correcting Hamming code, giving a 38-bit code word. A read decodes the stored code word and returns one corrected byte. A one-cycle flag marks a read whose word needed a bit flipped. A second flag marks a syndrome that cannot belong to any single-bit error.

Writes are byte-granular and use lane-aligned data with a byte-enable mask. When all four enables are set, the new word is encoded straight away and stored in one cycle. Any narrower write is a read-modify-write: the old code word is read, corrected, merged with the enabled bytes, re-encoded and written back. The block is busy for one extra cycle while it does this.

An injection mask XORs chosen code-word bits as a word is stored, so that faults can be planted.

Top module: `ecc_word_store`

## Requirements
- R1: After reset `ready_o` is 1, and `rvalid_o`, `corr_o` and `uncorr_o` are 0.
- R2: A write with all four byte enables set stores the whole word and leaves `ready_o` high in the following cycle.
- R3: A write with any byte enable clear drops `ready_o` for exactly the one cycle after acceptance. Bytes whose enable is set take the new data, and the other bytes keep their previous values.
- R4: A read accepted in one cycle raises `rvalid_o` in the next cycle, with `rdata_o` equal to byte `addr_i[1:0]` (byte 0 = bits 7:0) of word `addr_i[ADDR_W-1:2]`.
- R5: Code-word position p (1..38) is bit p-1 of `inj_i`. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bits 0..31 fill the other positions in ascending order, so data bit 3 sits at position 7. `inj_i` is XORed into the code word as it is stored.
- R6: A stored word with exactly one flipped bit, at any of the 38 positions, reads back exactly. `corr_o` is 1 and `uncorr_o` is 0, both only in the `rvalid_o` cycle.
- R7: A syndrome above 38 sets `uncorr_o` and clears `corr_o`, and the data is returned without any bit flipped. Flipping positions 32 and 7 is one such case, and it returns data bit 3 inverted.
- R8: A partial write corrects the old word before merging. After a one-bit fault in an unwritten byte and a partial write, reads return the old byte exactly with `corr_o` at 0.
- R9: When `wr_en_i` and `rd_en_i` are both high, only the write is performed, and `rvalid_o` stays 0 in the next cycle.
- R10: Requests presented while `ready_o` is 0 are ignored and leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address; upper bits pick the word, low 2 bits the byte |
| wr_en_i | input | 1 | Write request |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Lane-aligned write data |
| inj_i | input | 38 | Code-word bits to invert on store |
| rd_en_i | input | 1 | Read request |
| ready_o | output | 1 | Block accepts a request this cycle |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 8 | Corrected read byte |
| corr_o | output | 1 | Read fixed a single bit |
| uncorr_o | output | 1 | Read syndrome not correctable |

## Verification
The assertions assume that request inputs hold known values at every clock edge. They also assume that a request counts only in a cycle where `ready_o` is high. The stimulus fills every word before reading any, so no undefined contents are ever decoded. It drives requests only while `ready_o` is high, except in the one deliberate check of a request made during the merge cycle. It keeps `inj_i` at zero, one bit or the chosen two-bit pattern, so that each read's expected flag is known in advance.

// File: rtl/ecc_ws_pkg.sv
package ecc_ws_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CHK_W  = 6;
  localparam int unsigned CODE_W = DATA_W + CHK_W;
  localparam int unsigned BYTES  = DATA_W / 8;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [CHK_W-1:0]  syn_t;

  typedef enum logic {ST_IDLE, ST_MERGE} ws_state_e;

  // code position (1-based) of data bit idx: skip powers of two
  function automatic int data_pos(int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= int'(CODE_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  // data bits feeding check bit k
  function automatic word_t chk_mask(int k);
    word_t m;
    m = '0;
    for (int i = 0; i < int'(DATA_W); i++)
      if (((data_pos(i) >> k) & 1) != 0) m[i] = 1'b1;
    return m;
  endfunction

  // code bits feeding syndrome bit k
  function automatic code_t syn_mask(int k);
    code_t m;
    m = '0;
    for (int p = 1; p <= int'(CODE_W); p++)
      if (((p >> k) & 1) != 0) m[p-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_ws_enc.sv
module ecc_ws_enc
  import ecc_ws_pkg::*;
(
  input  word_t data_i,
  output code_t code_o
);
  for (genvar i = 0; i < int'(DATA_W); i++) begin : g_data
    localparam int P = data_pos(i);
    assign code_o[P-1] = data_i[i];
  end

  for (genvar k = 0; k < int'(CHK_W); k++) begin : g_chk
    localparam word_t M = chk_mask(k);
    assign code_o[(1<<k)-1] = ^(data_i & M);
  end
endmodule

// File: rtl/ecc_ws_dec.sv
module ecc_ws_dec
  import ecc_ws_pkg::*;
(
  input  code_t code_i,
  output word_t data_o,
  output logic  corr_o,
  output logic  uncorr_o
);
  syn_t  syn;
  code_t fixed;

  for (genvar k = 0; k < int'(CHK_W); k++) begin : g_syn
    localparam code_t M = syn_mask(k);
    assign syn[k] = ^(code_i & M);
  end

  assign corr_o   = (syn != '0) && (syn <= syn_t'(CODE_W));
  assign uncorr_o = syn > syn_t'(CODE_W);
  assign fixed    = code_i ^ (corr_o ? (code_t'(1) << (syn - 1'b1)) : '0);

  for (genvar i = 0; i < int'(DATA_W); i++) begin : g_data
    localparam int P = data_pos(i);
    assign data_o[i] = fixed[P-1];
  end
endmodule

// File: rtl/ecc_ws_mem.sv
module ecc_ws_mem #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned W     = 38,
  localparam int unsigned WORDS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] mem_q [WORDS];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
  import ecc_ws_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  input  logic [37:0]       inj_i,
  input  logic              rd_en_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [7:0]        rdata_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  localparam int unsigned OFS_W = $clog2(BYTES);
  localparam int unsigned IDX_W = ADDR_W - OFS_W;

  ws_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [BYTES-1:0] be_q;
  word_t            wdata_q;
  code_t            inj_q;
  logic             rd_pend_q;
  logic [OFS_W-1:0] sel_q;

  logic             idle, wr_go, rd_go, part_go;
  logic [IDX_W-1:0] idx_in;
  logic             mem_we, mem_re;
  logic [IDX_W-1:0] mem_waddr;
  code_t            mem_wdata, mem_rdata, enc_code;
  word_t            dec_data, merged, enc_in;
  logic             dec_corr, dec_unc;

  assign idle    = (state_q == ST_IDLE);
  assign idx_in  = addr_i[ADDR_W-1:OFS_W];
  assign wr_go   = idle & wr_en_i;
  assign rd_go   = idle & rd_en_i & ~wr_en_i;
  assign part_go = wr_go & ~(&be_i);

  // merge enabled new bytes over the corrected old word
  for (genvar b = 0; b < int'(BYTES); b++) begin : g_merge
    assign merged[b*8 +: 8] = be_q[b] ? wdata_q[b*8 +: 8] : dec_data[b*8 +: 8];
  end

  assign enc_in    = idle ? wdata_i : merged;
  assign mem_re    = rd_go | part_go;
  assign mem_we    = (wr_go & (&be_i)) | ~idle;
  assign mem_waddr = idle ? idx_in : idx_q;
  assign mem_wdata = enc_code ^ (idle ? inj_i : inj_q);

  ecc_ws_enc i_enc (
    .data_i (enc_in),
    .code_o (enc_code)
  );

  ecc_ws_mem #(.IDX_W(IDX_W), .W(CODE_W)) i_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .re_i    (mem_re),
    .raddr_i (idx_in),
    .rdata_o (mem_rdata)
  );

  ecc_ws_dec i_dec (
    .code_i   (mem_rdata),
    .data_o   (dec_data),
    .corr_o   (dec_corr),
    .uncorr_o (dec_unc)
  );

  always_comb begin
    state_d = ST_IDLE;
    if (part_go) state_d = ST_MERGE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      inj_q     <= '0;
      rd_pend_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      state_q   <= state_d;
      rd_pend_q <= rd_go;
      if (part_go) begin
        idx_q   <= idx_in;
        be_q    <= be_i;
        wdata_q <= wdata_i;
        inj_q   <= inj_i;
      end
      if (rd_go) sel_q <= addr_i[OFS_W-1:0];
    end
  end

  assign ready_o  = idle;
  assign rvalid_o = rd_pend_q;
  assign rdata_o  = dec_data[{sel_q, 3'b000} +: 8];
  assign corr_o   = rd_pend_q & dec_corr;
  assign uncorr_o = rd_pend_q & dec_unc;

  assert_full_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_en_i && (&be_i)) |=> ready_o);

  assert_merge_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_en_i && !(&be_i)) |=> !ready_o ##1 ready_o);

  assert_read_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rd_en_i && !wr_en_i) |=> rvalid_o);

  assert_flag_with_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o || uncorr_o) |-> rvalid_o);

  assert_flags_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_o && uncorr_o));

  assert_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_en_i) |=> !rvalid_o);

  assert_busy_no_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> !rvalid_o);
endmodule

// File: tb/test_ecc_word_store.sv
module test_ecc_word_store;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic        wr_en, rd_en;
  logic [3:0]  be;
  logic [31:0] wdata;
  logic [37:0] inj;
  logic        ready, rvalid, corr, uncorr;
  logic [7:0]  rdata;

  always #2 clk = ~clk;

  ecc_word_store i_ecc_word_store (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .be_i(be),
    .wdata_i(wdata), .inj_i(inj), .rd_en_i(rd_en), .ready_o(ready),
    .rvalid_o(rvalid), .rdata_o(rdata), .corr_o(corr), .uncorr_o(uncorr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [64];
  logic [9:0]  exp_q [$];
  string       tag_q [$];
  logic [9:0]  mon_e;
  string       mon_t;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [37:0] pbit(int p);
    return 38'(1) << (p - 1);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rvalid) begin
        if (exp_q.size() == 0) check(0, "R4", "unexpected rvalid", 1, 0);
        else begin
          mon_e = exp_q.pop_front();
          mon_t = tag_q.pop_front();
          check({corr, uncorr, rdata} == mon_e, mon_t, "read {corr,uncorr,data}",
                {corr, uncorr, rdata}, mon_e);
        end
      end else if (corr || uncorr) begin
        check(0, "R6", "flag without rvalid", {corr, uncorr}, 0);
      end
    end
  end

  task automatic wr(int idx, logic [31:0] d, logic [3:0] m, logic [37:0] fault, string tag);
    addr = {idx[5:0], 2'b00}; wr_en = 1'b1; be = m; wdata = d; inj = fault;
    @(negedge clk);
    wr_en = 1'b0; inj = '0;
    for (int b = 0; b < 4; b++) if (m[b]) model[idx][b*8 +: 8] = d[b*8 +: 8];
    if (&m) check(ready == 1'b1, "R2", {tag, " ready after full write"}, ready, 1);
    else begin
      check(ready == 1'b0, "R3", {tag, " ready during merge"}, ready, 0);
      @(negedge clk);
      check(ready == 1'b1, "R3", {tag, " ready after merge"}, ready, 1);
    end
  endtask

  task automatic rd(int idx, int b, logic [7:0] e, bit c, bit u, string tag);
    addr = {idx[5:0], b[1:0]}; rd_en = 1'b1;
    exp_q.push_back({c, u, e});
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_word(int idx, bit c, bit u, string tag);
    for (int b = 0; b < 4; b++) rd(idx, b, model[idx][b*8 +: 8], c, u, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R4", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; be = '0; wdata = '0; inj = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1", "ready after reset", ready, 1);
    check({rvalid, corr, uncorr} == 3'b000, "R1", "flags after reset",
          {rvalid, corr, uncorr}, 0);

    // R2 fill every word
    for (int i = 0; i < 64; i++) wr(i, (32'h9E3779B9 * (i + 1)) ^ i, 4'hF, '0, "R2");
    // R4 clean reads
    rd_word(0, 0, 0, "R4");
    rd_word(1, 0, 0, "R4");
    rd_word(63, 0, 0, "R4");

    // R3 partial writes with several masks
    wr(2, 32'hA1B2C3D4, 4'h1, '0, "R3");
    wr(3, 32'h55AA33CC, 4'h6, '0, "R3");
    wr(4, 32'h0F1E2D3C, 4'hA, '0, "R3");
    rd_word(2, 0, 0, "R3");
    rd_word(3, 0, 0, "R3");
    rd_word(4, 0, 0, "R3");

    // R6 every single-bit position, via full and partial writes
    for (int p = 1; p <= 38; p++) begin
      wr(20, 32'hC0DE0000 ^ (p * 32'h01010101), 4'hF, pbit(p), "R6");
      rd_word(20, 1, 0, "R6");
      wr(21, 32'h13570000 + p * 32'h00F1, 4'h3, pbit(p), "R6");
      rd_word(21, 1, 0, "R6");
    end

    // R8 old word corrected before merge
    wr(5, 32'h89ABCDEF, 4'hF, pbit(3), "R8");
    wr(5, 32'h7E000000, 4'h8, '0, "R8");
    rd_word(5, 0, 0, "R8");

    // R7 / R5: positions 32 and 7 -> syndrome 39, data bit 3 left inverted
    d = 32'h2468ACE0;
    wr(9, d, 4'hF, pbit(32) | pbit(7), "R7");
    rd(9, 0, d[7:0] ^ 8'h08, 0, 1, "R7");
    rd(9, 1, d[15:8], 0, 1, "R5");

    // R9 write wins over simultaneous read
    addr = {6'd30, 2'b00}; wr_en = 1; rd_en = 1; be = 4'hF; wdata = 32'hFACE0FF5;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    model[30] = 32'hFACE0FF5;
    check(rvalid == 1'b0, "R9", "rvalid after write+read", rvalid, 0);
    rd_word(30, 0, 0, "R9");

    // R10 request during merge cycle is dropped
    addr = {6'd10, 2'b00}; wr_en = 1; be = 4'h1; wdata = 32'h000000AB;
    @(negedge clk);
    check(ready == 1'b0, "R10", "ready during merge", ready, 0);
    addr = {6'd11, 2'b00}; be = 4'hF; wdata = 32'hDEADBEEF;
    @(negedge clk);
    wr_en = 0;
    model[10][7:0] = 8'hAB;
    check(ready == 1'b1, "R10", "ready after merge", ready, 1);
    rd_word(11, 0, 0, "R10");
    rd_word(10, 0, 0, "R10");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4", "reads left pending", exp_q.size(), 0);
    finish_run();
  end
endmodule